// File: doc/BRIEF.md
# Soft-start and fault sequencer

This block decides, once per switching cycle, what the PWM channels of a multiphase buck regulator are allowed to do. It takes a switching-cycle tick, a supply-good level, a disable request and the digital outputs of the protection comparators. It produces three outputs:

- a PWM mode: three-state, forced low, or normal run;
- an enable for the reference ramp;
- a power-good flag.

All start-up and fault intervals are measured in switching cycles on one shared counter. Only clock cycles with the tick high advance that counter.

A fresh start holds the channels three-stated for a short wait. It then clamps them low while the analog loop settles. After that it releases them to run while the reference climbs from zero. Power-good is withheld until a fixed number of cycles after the start.

An overcurrent during clamp or run triggers a hiccup: the block restarts with a much longer three-state wait. An overvoltage latches the block into a hysteretic shunt mode that only a supply cycle clears. An undervoltage merely masks power-good.

Top module: `softstart_fault_seq`

## Requirements
- R1: While `supply_ok` is low, `pwm_mode` is 0 (three-state), `ramp_en` and `pgood` are low and the sequence returns to its idle start point. This holds whatever the other inputs do. While `dis_req` is high outside the overvoltage latch, the outputs take the same values.
- R2: On the first clock with `supply_ok` high and `dis_req` low, a start begins. `pwm_mode` stays 0 until HOLD_CYC ticks have been counted since that clock.
- R3: After the hold, `pwm_mode` is 1 (forced low) for CLAMP_CYC ticks. It is then 2 (run), and `ramp_en` is high exactly while `pwm_mode` is 2.
- R4: Clock cycles with `cyc_tick` low do not advance any interval.
- R5: `pgood` is high only in run, only once PGOOD_CYC ticks have passed since the start, and only while `uv_flag` and `ov_above` are low.
- R6: `uv_flag` drops `pgood` on the same clock edge. It does not change `pwm_mode` and is not remembered once it clears.
- R7: `oc_flag` during clamp or run sets `pwm_mode` to 0 and drops `pgood`. The block then waits HICCUP_CYC ticks three-stated, clamps low for CLAMP_CYC ticks and runs. In that retry, `pgood` may rise HICCUP_CYC+PGOOD_CYC-HOLD_CYC ticks after the restart. A further overcurrent repeats the retry.
- R8: `ov_above` outside idle latches the overvoltage state, in which `ramp_en` and `pgood` stay low. While latched, `pwm_mode` is 1 when `ov_above` is high. It is 0 after `ov_below` goes high, and it keeps its last value while neither flag is high.
- R9: The overvoltage latch ignores `dis_req` and `oc_flag`, and it never restarts a soft start by itself. Only `supply_ok` going low clears it, after which a new start uses the short hold.
- R10: When `ov_above` and `oc_flag` are high together, the overvoltage response wins (`pwm_mode` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| supply_ok | input | 1 | Bias supply above its power-on threshold |
| dis_req | input | 1 | Converter disable request |
| oc_flag | input | 1 | Averaged current above trip level |
| ov_above | input | 1 | Output above the overvoltage threshold |
| ov_below | input | 1 | Output below threshold minus hysteresis |
| uv_flag | input | 1 | Output below the undervoltage threshold |
| pwm_mode | output | 2 | 0 three-state, 1 forced low, 2 run |
| ramp_en | output | 1 | Reference ramp enabled |
| pgood | output | 1 | Power-good |

## Verification
The hardest region to reach is the hysteretic overvoltage latch, where neither comparator flag is high and the outputs must keep their last value. The stimulus enters this region from both the forced-low side and the three-state side. It also applies disable and overcurrent while latched, to show that neither frees the block.

A second hard case is the hiccup timing. Its longer power-good window exists only after a restart caused by overcurrent. The bench therefore reaches run first, injects the fault, and sweeps every cycle of the retry. It also injects a second fault in the middle of a clamp. Gapped ticks confirm that only tick cycles count.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_CLAMP = 3'd2,
    ST_RUN   = 3'd3,
    ST_OVL   = 3'd4
  } seq_st_t;

  typedef enum logic [1:0] {
    PM_TRI = 2'd0,
    PM_LOW = 2'd1,
    PM_RUN = 2'd2
  } pwm_mode_t;
endpackage

// File: rtl/sfs_cycle_cnt.sv
module sfs_cycle_cnt #(
  parameter int unsigned W = 12,
  parameter int unsigned MAXV = 4064
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (inc && (cnt_q != TOP))
      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfs_ov_shunt.sv
module sfs_ov_shunt (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic enter,
  input  logic ov_above,
  input  logic ov_below,
  output logic low_d,
  output logic low_q
);
  always_comb begin
    low_d = low_q;
    if (!active)
      low_d = 1'b0;
    else if (enter || ov_above)
      low_d = 1'b1;
    else if (ov_below)
      low_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) low_q <= 1'b0;
    else     low_q <= low_d;
  end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int unsigned W = 12,
  parameter int unsigned HOLD_CYC = 32,
  parameter int unsigned CLAMP_CYC = 150,
  parameter int unsigned HICCUP_CYC = 2048
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         supply_ok,
  input  logic         dis_req,
  input  logic         oc_flag,
  input  logic         ov_above,
  input  logic [W-1:0] cnt_q,
  output seq_st_t      st_q,
  output seq_st_t      st_d,
  output logic         long_d,
  output logic         cnt_clr,
  output logic         cnt_inc
);
  localparam logic [W-1:0] HOLD_W  = W'(HOLD_CYC);
  localparam logic [W-1:0] HIC_W   = W'(HICCUP_CYC);
  localparam logic [W-1:0] CLAMP_W = W'(CLAMP_CYC);

  logic         long_q;
  logic [W-1:0] hold_len;
  logic [W-1:0] cnt_p1;

  assign hold_len = long_q ? HIC_W : HOLD_W;
  assign cnt_p1   = cnt_q + W'(1);

  always_comb begin
    st_d    = st_q;
    long_d  = long_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!supply_ok) begin
      st_d    = ST_IDLE;
      long_d  = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!dis_req) begin
            st_d    = ST_HOLD;
            long_d  = 1'b0;
            cnt_clr = 1'b1;
          end
        end
        ST_OVL: st_d = ST_OVL;
        default: begin
          if (ov_above) begin
            st_d = ST_OVL;
          end else if (dis_req) begin
            st_d    = ST_IDLE;
            long_d  = 1'b0;
            cnt_clr = 1'b1;
          end else if (oc_flag && (st_q != ST_HOLD)) begin
            st_d    = ST_HOLD;
            long_d  = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = tick;
            if (tick) begin
              if ((st_q == ST_HOLD) && (cnt_p1 == hold_len))
                st_d = ST_CLAMP;
              else if ((st_q == ST_CLAMP) && (cnt_p1 == hold_len + CLAMP_W))
                st_d = ST_RUN;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      long_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      long_q <= long_d;
    end
  end
endmodule

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq
  import sfs_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 32,
  parameter int unsigned CLAMP_CYC = 150,
  parameter int unsigned PGOOD_CYC = 2048,
  parameter int unsigned HICCUP_CYC = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_tick,
  input  logic       supply_ok,
  input  logic       dis_req,
  input  logic       oc_flag,
  input  logic       ov_above,
  input  logic       ov_below,
  input  logic       uv_flag,
  output logic [1:0] pwm_mode,
  output logic       ramp_en,
  output logic       pgood
);
  localparam int unsigned PG_RETRY = HICCUP_CYC + PGOOD_CYC - HOLD_CYC;
  localparam int unsigned CW = $clog2(PG_RETRY + 1);
  localparam logic [CW-1:0] PG_FRESH_W = CW'(PGOOD_CYC);
  localparam logic [CW-1:0] PG_RETRY_W = CW'(PG_RETRY);

  seq_st_t       st_q, st_d;
  logic          long_d, cnt_clr, cnt_inc;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          low_d, low_q;
  logic [CW-1:0] pg_at;
  pwm_mode_t     mode_d;

  sfs_cycle_cnt #(.W(CW), .MAXV(PG_RETRY)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  sfs_ctrl #(
    .W(CW), .HOLD_CYC(HOLD_CYC), .CLAMP_CYC(CLAMP_CYC), .HICCUP_CYC(HICCUP_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(cyc_tick), .supply_ok(supply_ok),
    .dis_req(dis_req), .oc_flag(oc_flag), .ov_above(ov_above),
    .cnt_q(cnt_q), .st_q(st_q), .st_d(st_d), .long_d(long_d),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
  );

  sfs_ov_shunt u_shunt (
    .clk(clk), .rst(rst),
    .active(st_d == ST_OVL),
    .enter((st_d == ST_OVL) && (st_q != ST_OVL)),
    .ov_above(ov_above), .ov_below(ov_below),
    .low_d(low_d), .low_q(low_q)
  );

  assign pg_at = long_d ? PG_RETRY_W : PG_FRESH_W;

  always_comb begin
    case (st_d)
      ST_RUN:   mode_d = PM_RUN;
      ST_CLAMP: mode_d = PM_LOW;
      ST_OVL:   mode_d = low_d ? PM_LOW : PM_TRI;
      default:  mode_d = PM_TRI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_mode <= PM_TRI;
      ramp_en  <= 1'b0;
      pgood    <= 1'b0;
    end else begin
      pwm_mode <= mode_d;
      ramp_en  <= (st_d == ST_RUN);
      pgood    <= (st_d == ST_RUN) && (cnt_d >= pg_at) && !uv_flag && !ov_above;
    end
  end
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       dis_req,
  input logic       oc_flag,
  input logic       ov_above,
  input logic       uv_flag,
  input logic [1:0] pwm_mode,
  input logic       ramp_en,
  input logic       pgood
);
  a_r1_supply_loss: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (pwm_mode == 2'd0 && !pgood && !ramp_en));

  a_r5_pgood_in_run: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (pwm_mode == 2'd2 && ramp_en));

  a_r6_uv_masks: assert property (@(posedge clk) disable iff (rst)
    uv_flag |=> !pgood);

  a_r7_oc_tristate: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && !dis_req && !ov_above && oc_flag && pwm_mode == 2'd2) |=> pwm_mode == 2'd0);

  a_r8_ov_clamps_low: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && ov_above && pwm_mode != 2'd0) |=> (pwm_mode == 2'd1 && !pgood));
endmodule

bind softstart_fault_seq sfs_chk u_sfs_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .dis_req(dis_req),
  .oc_flag(oc_flag), .ov_above(ov_above), .uv_flag(uv_flag),
  .pwm_mode(pwm_mode), .ramp_en(ramp_en), .pgood(pgood)
);

// File: tb/tb_softstart_fault_seq.sv
module tb_softstart_fault_seq;
  localparam int CLK_P = 10;
  localparam int HOLD = 4;
  localparam int CLAMP = 6;
  localparam int PGOOD = 32;
  localparam int HIC = 16;
  localparam int PG_HIC = HIC + PGOOD - HOLD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_tick = 1'b0, supply_ok = 1'b0, dis_req = 1'b0, oc_flag = 1'b0;
  logic ov_above = 1'b0, ov_below = 1'b0, uv_flag = 1'b0;
  logic [1:0] pwm_mode;
  logic ramp_en, pgood;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  softstart_fault_seq #(
    .HOLD_CYC(HOLD), .CLAMP_CYC(CLAMP), .PGOOD_CYC(PGOOD), .HICCUP_CYC(HIC)
  ) dut (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .supply_ok(supply_ok),
    .dis_req(dis_req), .oc_flag(oc_flag), .ov_above(ov_above),
    .ov_below(ov_below), .uv_flag(uv_flag),
    .pwm_mode(pwm_mode), .ramp_en(ramp_en), .pgood(pgood)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mode_at(int m, int hold);
    if (m < hold) return 0;
    if (m < hold + CLAMP) return 1;
    return 2;
  endfunction

  task automatic check_seq(input string tag, input int m, input int hold, input int pg_at);
    chk({tag, " mode"}, 32'(pwm_mode), 32'(mode_at(m, hold)));
    chk({tag, " ramp"}, 32'(ramp_en), 32'(m >= hold + CLAMP));
    chk({tag, " pgood"}, 32'(pgood), 32'(m >= pg_at));
  endtask

  function automatic string seq_tag(int m, int hold);
    if (m < hold) return "R2";
    if (m < hold + CLAMP) return "R3";
    return "R5";
  endfunction

  initial begin
    repeat (3) step();
    chk("R1 reset mode", 32'(pwm_mode), 0);
    chk("R1 reset pgood", 32'(pgood), 0);
    chk("R1 reset ramp", 32'(ramp_en), 0);
    rst = 1'b0;
    step();
    chk("R1 no supply mode", 32'(pwm_mode), 0);

    // fresh start, tick every clock
    supply_ok = 1'b1; cyc_tick = 1'b1;
    step();
    for (int m = 0; m <= 40; m++) begin
      check_seq(seq_tag(m, HOLD), m, HOLD, PGOOD);
      step();
    end

    // R6 undervoltage masks pgood only
    uv_flag = 1'b1; step();
    chk("R6 pgood", 32'(pgood), 0);
    chk("R6 mode", 32'(pwm_mode), 2);
    uv_flag = 1'b0; step();
    chk("R6 pgood back", 32'(pgood), 1);

    // R7 hiccup retry, full sweep
    oc_flag = 1'b1; step(); oc_flag = 1'b0;
    for (int m = 0; m <= 50; m++) begin
      check_seq("R7", m, HIC, PG_HIC);
      step();
    end
    // R7 second fault from run, then a third fault during clamp
    oc_flag = 1'b1; step(); oc_flag = 1'b0;
    for (int m = 0; m <= HIC + 2; m++) begin
      check_seq("R7 repeat", m, HIC, PG_HIC);
      step();
    end
    oc_flag = 1'b1; step(); oc_flag = 1'b0;
    for (int m = 0; m <= HIC + CLAMP; m++) begin
      check_seq("R7 clamp fault", m, HIC, PG_HIC);
      step();
    end

    // R1 disable
    dis_req = 1'b1; step();
    chk("R1 disable mode", 32'(pwm_mode), 0);
    chk("R1 disable ramp", 32'(ramp_en), 0);
    chk("R1 disable pgood", 32'(pgood), 0);
    repeat (3) step();
    chk("R1 disable held", 32'(pwm_mode), 0);

    // R4 gapped ticks after release
    dis_req = 1'b0; cyc_tick = 1'b0; step();
    begin
      int m = 0;
      for (int c = 0; c < 100 && m < HOLD + CLAMP + 2; c++) begin
        cyc_tick = ((c % 3) == 2);
        step();
        if (cyc_tick) m++;
        chk("R4 gapped mode", 32'(pwm_mode), 32'(mode_at(m, HOLD)));
      end
    end
    cyc_tick = 1'b1;

    // R10 and R8 overvoltage latch
    ov_above = 1'b1; oc_flag = 1'b1; step();
    chk("R10 ov beats oc", 32'(pwm_mode), 1);
    chk("R8 pgood", 32'(pgood), 0);
    chk("R8 ramp", 32'(ramp_en), 0);
    oc_flag = 1'b0; ov_above = 1'b0; step();
    chk("R8 hold low", 32'(pwm_mode), 1);
    ov_below = 1'b1; step();
    chk("R8 below tri", 32'(pwm_mode), 0);
    ov_below = 1'b0; step();
    chk("R8 hold tri", 32'(pwm_mode), 0);
    ov_above = 1'b1; step();
    chk("R8 above low", 32'(pwm_mode), 1);
    ov_above = 1'b0; step();
    chk("R8 hold low again", 32'(pwm_mode), 1);
    dis_req = 1'b1; step();
    chk("R9 disable ignored", 32'(pwm_mode), 1);
    oc_flag = 1'b1; step();
    chk("R9 oc ignored", 32'(pwm_mode), 1);
    dis_req = 1'b0; oc_flag = 1'b0; ov_below = 1'b1; step();
    chk("R9 shunt tri", 32'(pwm_mode), 0);
    ov_below = 1'b0;
    repeat (20) step();
    chk("R9 no restart mode", 32'(pwm_mode), 0);
    chk("R9 no restart pgood", 32'(pgood), 0);
    chk("R9 no restart ramp", 32'(ramp_en), 0);

    // R1 supply loss beats everything; R9 latch cleared
    supply_ok = 1'b0; ov_above = 1'b1; oc_flag = 1'b1; step();
    chk("R1 supply loss priority", 32'(pwm_mode), 0);
    ov_above = 1'b0; oc_flag = 1'b0; step();
    supply_ok = 1'b1; step();
    for (int m = 0; m <= HOLD + CLAMP; m++) begin
      check_seq("R9 restart", m, HOLD, PGOOD);
      step();
    end
    supply_ok = 1'b0; step();
    chk("R1 drop in run mode", 32'(pwm_mode), 0);
    chk("R1 drop in run ramp", 32'(ramp_en), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule